// File: doc/BRIEF.md
# Page Access Protection Checker

This block judges every virtual memory access of a processor against a table of page descriptors, one table per privilege mode. The top three bits of a 16-bit virtual address pick one of eight pages; the next seven bits give the 64-byte block within that page. That block number is compared against the page's length field. Whether the page is present and writable comes from the descriptor's access-control code. The abort decision is combinational and is reported in the same cycle as the access.

When an access fails, the block records why in status register 0: which checks failed, the mode and the page. Status register 2 receives the virtual address. Both registers then hold still until software clears the abort flags. Register 3 picks, for each mode, whether data accesses use a separate set of data-space descriptors. It also carries two enable bits that are only stored.

The reserved mode code 2 (binary 10) is illegal. Every access made in that mode aborts, whatever the descriptors hold.

All registers sit behind one 8-bit select:
- Control registers: select bit 7 = 1. Bits 1:0 give 0 for register 0, 1 for register 2 and 2 for register 3.
- Page registers: select bit 7 = 0. Bit 6 is 0 for a descriptor and 1 for an address register. Bits 5:4 give the mode, bit 3 the space (0 instruction, 1 data) and bits 2:0 the page.

Top module: `mmu_access_checker`

## Requirements
- R1: After reset, registers 0, 2 and 3 read zero and no access aborts.
- R2: While register 0 bit 0 (enable) is clear, no access aborts and registers 0 and 2 keep their contents.
- R3: The access-control code sits in descriptor bits 2:0.
  - Code 6 allows reads and writes.
  - Code 2 allows reads; a write aborts and sets register 0 bit 13.
  - Every other code means non-resident: any access aborts and sets register 0 bit 15 alone.
- R4: The length field sits in descriptor bits 14:8 and the direction bit in bit 3. With direction 0 (upward), an access whose block number (address bits 12:6) exceeds the length aborts and sets register 0 bit 14.
- R5: With direction 1 (downward), an access whose block number is below the length aborts and sets register 0 bit 14. A block equal to the length passes in both directions.
- R6: Every access in mode 2 aborts with bits 15 and 14 both set, whatever the descriptor holds, provided the block is enabled.
- R7: On an abort recorded with no abort flag already set:
  - register 0 takes the flags in bits 15:13, the mode in bits 6:5 and the page in bits 3:1, and bit 7 is cleared;
  - register 2 takes the full virtual address.
- R8: While any of register 0 bits 15:13 is set, further aborts still assert the abort output but change neither register 0 nor register 2. A write to register 0 replaces it.
- R9: Register 0 implements only bits 15:13, 7:5, 3:1 and 0 (mask 0xE0EF). All other bits, including 11 and 10, read zero after any write.
- R10: Register 3 implements only bits 5, 4, 2, 1 and 0 (mask 0x0037) and reads zero elsewhere. Reset clears it.
- R11: A data access (instruction-fetch flag low) uses the data-space descriptor when register 3 enables data space for its mode: bit 2 for kernel (mode 0), bit 1 for supervisor (mode 1) and bit 0 for user (mode 3). An instruction fetch always uses the instruction-space descriptor.
- R12: Every address register of modes 0, 1 and 3 reads back all 16 written bits. Descriptors read back only bits 14:8, 3 and 2:0. Page-register writes to mode-2 slots are ignored, and those slots read zero.
- R13: When a write to register 0 and an aborting access fall in the same cycle, the written value wins in register 0, register 2 is not updated, and the abort output is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 8 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the selected register (combinational) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mode | input | 2 | CPU mode of the access (0 kernel, 1 supervisor, 2 illegal, 3 user) |
| acc_vaddr | input | 16 | Virtual address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_ifetch | input | 1 | 1 for an instruction fetch |
| acc_abort | output | 1 | The access is refused |

## Verification
Two functions can collide in one cycle: software rewriting register 0 and the capture of a new abort into registers 0 and 2. The bench drives a register-0 write and an illegal-mode access on the same clock edge. It then judges three things: the abort output is high in that cycle, register 0 afterwards holds exactly the written value, and register 2 still holds the address captured before. A similar overlap, an abort arriving while an earlier one is still frozen, is provoked by two failing accesses in a row with no clear between them.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

    localparam int VA_W   = 16;
    localparam int WORD_W = 16;
    localparam int PG_W   = 3;
    localparam int LEN_W  = 7;
    localparam int ACF_W  = 3;
    localparam int BLK_LO = VA_W - PG_W - LEN_W;

    localparam logic [1:0] MODE_KERN = 2'd0;
    localparam logic [1:0] MODE_SUPV = 2'd1;
    localparam logic [1:0] MODE_BAD  = 2'd2;
    localparam logic [1:0] MODE_USER = 2'd3;

    localparam logic [ACF_W-1:0] ACF_RO = 3'd2;
    localparam logic [ACF_W-1:0] ACF_RW = 3'd6;

    localparam logic [WORD_W-1:0] SR0_MASK = 16'hE0EF;
    localparam logic [WORD_W-1:0] SR3_MASK = 16'h0037;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             down;
        logic [ACF_W-1:0] acf;
    } pg_desc_t;

    typedef struct packed {
        logic nonres;
        logic len_err;
        logic rd_only;
    } abort_flags_t;

    function automatic logic [WORD_W-1:0] desc_to_word(pg_desc_t d);
        return {1'b0, d.len, 4'b0000, d.down, d.acf};
    endfunction

    function automatic pg_desc_t word_to_desc(logic [WORD_W-1:0] w);
        pg_desc_t d;
        d.len  = w[14:8];
        d.down = w[3];
        d.acf  = w[2:0];
        return d;
    endfunction

endpackage

// File: rtl/mmu_page_file.sv
module mmu_page_file
    import mmu_chk_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_par,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_par,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  lk_idx,
    output pg_desc_t          lk_desc
);
    localparam int NUM = 1 << IDX_W;

    typedef struct packed {
        pg_desc_t [NUM-1:0]              desc;
        logic     [NUM-1:0][WORD_W-1:0]  par;
    } file_t;

    file_t st_d, st_q;
    logic  slot_ok;

    assign slot_ok = (wr_idx[IDX_W-1 -: 2] != MODE_BAD);

    always_comb begin
        st_d = st_q;
        if (wr_en && slot_ok) begin
            if (wr_par) begin
                st_d.par[wr_idx] = wdata;
            end else begin
                st_d.desc[wr_idx] = word_to_desc(wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = rd_par ? st_q.par[rd_idx] : desc_to_word(st_q.desc[rd_idx]);
    assign lk_desc = st_q.desc[lk_idx];

    AST_BAD_SLOT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1 -: 2] == MODE_BAD) |=> $stable(st_q)); // R12

endmodule

// File: rtl/mmu_access_eval.sv
module mmu_access_eval
    import mmu_chk_pkg::*;
(
    input  logic             enable,
    input  logic             valid,
    input  logic [1:0]       mode,
    input  logic [LEN_W-1:0] blk,
    input  logic             write,
    input  pg_desc_t         desc,
    output abort_flags_t     flags
);
    logic resident;

    assign resident = (desc.acf == ACF_RO) || (desc.acf == ACF_RW);

    always_comb begin
        flags = '0;
        if (valid && enable) begin
            if (mode == MODE_BAD) begin
                flags.nonres  = 1'b1;
                flags.len_err = 1'b1;
            end else if (!resident) begin
                flags.nonres = 1'b1;
            end else begin
                flags.len_err = desc.down ? (blk < desc.len) : (blk > desc.len);
                flags.rd_only = write && (desc.acf == ACF_RO);
            end
        end
    end

endmodule

// File: rtl/mmu_status_regs.sv
module mmu_status_regs
    import mmu_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr3,
    input  logic [WORD_W-1:0] wdata,
    input  abort_flags_t      flags,
    input  logic [1:0]        mode,
    input  logic [VA_W-1:0]   vaddr,
    output logic [WORD_W-1:0] sr0,
    output logic [WORD_W-1:0] sr2,
    output logic [WORD_W-1:0] sr3
);
    typedef struct packed {
        logic [WORD_W-1:0] sr0;
        logic [WORD_W-1:0] sr2;
        logic [WORD_W-1:0] sr3;
    } stat_t;

    stat_t st_d, st_q;
    logic  frozen;
    logic  hit;

    assign frozen = |st_q.sr0[15:13];
    assign hit    = |flags;

    always_comb begin
        st_d = st_q;
        if (wr0) begin
            st_d.sr0 = wdata & SR0_MASK;
        end else if (hit && !frozen) begin
            st_d.sr0[15:13] = flags;
            st_d.sr0[7]     = 1'b0;
            st_d.sr0[6:5]   = mode;
            st_d.sr0[3:1]   = vaddr[VA_W-1 -: PG_W];
            st_d.sr2        = vaddr;
        end
        if (wr3) begin
            st_d.sr3 = wdata & SR3_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr0 = st_q.sr0;
    assign sr2 = st_q.sr2;
    assign sr3 = st_q.sr3;

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !wr0) |=> ($stable(sr0) && $stable(sr2))); // R8
    AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !frozen && !wr0) |=> (sr2 == $past(vaddr) && sr0[6:5] == $past(mode))); // R7
    AST_WRITE_BEATS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && hit) |=> $stable(sr2)); // R13
    AST_SR3_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sr3 & ~SR3_MASK) == '0); // R10

endmodule

// File: rtl/mmu_access_checker.sv
module mmu_access_checker
    import mmu_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        acc_valid,
    input  logic [1:0]  acc_mode,
    input  logic [15:0] acc_vaddr,
    input  logic        acc_write,
    input  logic        acc_ifetch,
    output logic        acc_abort
);
    localparam int IDX_W = 2 + 1 + PG_W;

    logic              is_ctl;
    logic              wr0, wr3, wr_pg;
    logic [WORD_W-1:0] sr0, sr2, sr3, pg_rdata;
    logic              dspace;
    logic [IDX_W-1:0]  lk_idx;
    pg_desc_t          lk_desc;
    abort_flags_t      flags;

    assign is_ctl = cfg_sel[7];
    assign wr0    = cfg_we && is_ctl && (cfg_sel[1:0] == 2'd0);
    assign wr3    = cfg_we && is_ctl && (cfg_sel[1:0] == 2'd2);
    assign wr_pg  = cfg_we && !is_ctl;

    always_comb begin
        case (acc_mode)
            MODE_KERN: dspace = sr3[2];
            MODE_SUPV: dspace = sr3[1];
            MODE_USER: dspace = sr3[0];
            default:   dspace = 1'b0;
        endcase
        if (acc_ifetch) begin
            dspace = 1'b0;
        end
    end

    assign lk_idx = {acc_mode, dspace, acc_vaddr[VA_W-1 -: PG_W]};

    mmu_page_file #(.IDX_W(IDX_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_pg),
        .wr_par  (cfg_sel[6]),
        .wr_idx  (cfg_sel[IDX_W-1:0]),
        .wdata   (cfg_wdata),
        .rd_par  (cfg_sel[6]),
        .rd_idx  (cfg_sel[IDX_W-1:0]),
        .rd_data (pg_rdata),
        .lk_idx  (lk_idx),
        .lk_desc (lk_desc)
    );

    mmu_access_eval u_eval (
        .enable (sr0[0]),
        .valid  (acc_valid),
        .mode   (acc_mode),
        .blk    (acc_vaddr[BLK_LO +: LEN_W]),
        .write  (acc_write),
        .desc   (lk_desc),
        .flags  (flags)
    );

    mmu_status_regs u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr0   (wr0),
        .wr3   (wr3),
        .wdata (cfg_wdata),
        .flags (flags),
        .mode  (acc_mode),
        .vaddr (acc_vaddr),
        .sr0   (sr0),
        .sr2   (sr2),
        .sr3   (sr3)
    );

    assign acc_abort = |flags;

    always_comb begin
        if (is_ctl) begin
            case (cfg_sel[1:0])
                2'd0:    cfg_rdata = sr0;
                2'd1:    cfg_rdata = sr2;
                2'd2:    cfg_rdata = sr3;
                default: cfg_rdata = '0;
            endcase
        end else begin
            cfg_rdata = pg_rdata;
        end
    end

    AST_BAD_MODE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sr0[0] && acc_mode == MODE_BAD) |-> acc_abort); // R6
    AST_NO_ABORT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !sr0[0] |-> !acc_abort); // R2
    AST_SR0_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 8'h80) |-> ((cfg_rdata & ~SR0_MASK) == '0)); // R9

endmodule

// File: tb/tb_mmu_access_checker.sv
module tb_mmu_access_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_sel = 8'h80;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_mode = '0;
    logic [15:0] acc_vaddr = '0;
    logic        acc_write = 1'b0;
    logic        acc_ifetch = 1'b0;
    logic        acc_abort;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] idle0 = 16'h0001;

    always #5 clk = ~clk;

    mmu_access_checker dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] sel, output logic [15:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic access(input logic [1:0] m, input logic [15:0] va, input logic wr,
                          input logic ifc, output logic ab);
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = m; acc_vaddr = va; acc_write = wr; acc_ifetch = ifc;
        #1 ab = acc_abort;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [15:0] dword(input logic [6:0] len, input logic down, input logic [2:0] acf);
        return {1'b0, len, 4'b0000, down, acf};
    endfunction

    function automatic logic [7:0] psel(input logic par, input logic [1:0] m, input logic sp, input logic [2:0] pg);
        return {1'b0, par, m, sp, pg};
    endfunction

    function automatic logic [2:0] model(input logic [1:0] m, input logic [6:0] blk, input logic [6:0] len,
                                         input logic down, input logic [2:0] acf, input logic wr);
        logic [2:0] f;
        f = 3'b000;
        if (m == 2'd2) f = 3'b110;
        else if (acf != 3'd2 && acf != 3'd6) f = 3'b100;
        else begin
            f[1] = down ? (blk < len) : (blk > len);
            f[0] = wr && (acf == 3'd2);
        end
        return f;
    endfunction

    // apply one access and judge output, register 0 and register 2
    task automatic probe(input string req, input logic [1:0] m, input logic [15:0] va,
                         input logic wr, input logic ifc, input logic [2:0] ef);
        logic ab;
        logic [15:0] r;
        access(m, va, wr, ifc, ab);
        check({req, " abort"}, {15'b0, ab}, {15'b0, |ef});
        cfg_read(8'h80, r);
        if (|ef) begin
            check({req, " R7 reg0"}, r, {ef, 5'b0, 1'b0, m, 1'b0, va[15:13], 1'b1});
            cfg_read(8'h81, r);
            check({req, " R7 reg2"}, r, va);
            cfg_write(8'h80, idle0);
        end else begin
            check({req, " reg0 idle"}, r, idle0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r, saved;
        logic ab;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read(8'h80, r); check("R1 reg0", r, 16'h0000);
        cfg_read(8'h81, r); check("R1 reg2", r, 16'h0000);
        cfg_read(8'h82, r); check("R1 reg3", r, 16'h0000);
        access(2'd2, 16'h4321, 1'b0, 1'b0, ab);
        check("R1 R2 no abort after reset", {15'b0, ab}, 16'h0000);

        // R9 register 0 implemented bits
        cfg_write(8'h80, 16'hFFFF); cfg_read(8'h80, r); check("R9 reg0 all ones", r, 16'hE0EF);
        cfg_write(8'h80, 16'h0C00); cfg_read(8'h80, r); check("R9 reg0 bits 11:10", r, 16'h0000);

        // R10 register 3 implemented bits
        cfg_write(8'h82, 16'hFFFF); cfg_read(8'h82, r); check("R10 reg3 all ones", r, 16'h0037);
        cfg_write(8'h82, 16'h0000); cfg_read(8'h82, r); check("R10 reg3 cleared", r, 16'h0000);

        // R12 address registers and descriptors read back
        for (int i = 0; i < 64; i++) begin
            cfg_write({2'b01, i[5:0]}, 16'hA5C3 ^ {i[7:0], i[7:0]});
        end
        for (int i = 0; i < 64; i++) begin
            cfg_read({2'b01, i[5:0]}, r);
            check("R12 address reg", r, (i[5:4] == 2'd2) ? 16'h0000 : (16'hA5C3 ^ {i[7:0], i[7:0]}));
        end
        cfg_write(psel(1'b0, 2'd0, 1'b0, 3'd0), 16'hFFFF);
        cfg_read(psel(1'b0, 2'd0, 1'b0, 3'd0), r); check("R12 descriptor fields", r, 16'h7F0F);
        cfg_write(psel(1'b0, 2'd2, 1'b0, 3'd0), 16'hFFFF);
        cfg_read(psel(1'b0, 2'd2, 1'b0, 3'd0), r); check("R12 mode-2 slot ignored", r, 16'h0000);

        // R2 disabled: non-resident page, no abort, no record
        cfg_write(psel(1'b0, 2'd0, 1'b0, 3'd0), dword(7'd0, 1'b0, 3'd0));
        cfg_write(8'h80, 16'h0000);
        access(2'd0, 16'h0040, 1'b1, 1'b0, ab);
        check("R2 no abort when disabled", {15'b0, ab}, 16'h0000);
        cfg_read(8'h80, r); check("R2 reg0 unchanged", r, 16'h0000);
        cfg_read(8'h81, r); check("R2 reg2 unchanged", r, 16'h0000);

        // enable; bit 7 set in idle value so its clearing on record is seen (R7)
        idle0 = 16'h0081;
        cfg_write(8'h80, idle0);

        // R3 access-control sweep
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            for (int a = 0; a < 8; a++) begin
                cfg_write(psel(1'b0, m[1:0], 1'b0, 3'd2), dword(7'd127, 1'b0, a[2:0]));
                for (int w = 0; w < 2; w++) begin
                    probe("R3 access code", m[1:0], {3'd2, 7'd5, 6'h2A}, w[0], 1'b0,
                          model(m[1:0], 7'd5, 7'd127, 1'b0, a[2:0], w[0]));
                end
            end
        end

        // R4 / R5 length sweep, both directions
        for (int dn = 0; dn < 2; dn++) begin
            for (int li = 0; li < 3; li++) begin
                logic [6:0] len;
                len = (li == 0) ? 7'd0 : (li == 1) ? 7'd45 : 7'd127;
                cfg_write(psel(1'b0, 2'd0, 1'b0, 3'd6), dword(len, dn[0], 3'd6));
                for (int b = 0; b < 128; b++) begin
                    probe(dn[0] ? "R5 downward length" : "R4 upward length", 2'd0,
                          {3'd6, b[6:0], 6'h15}, 1'b0, 1'b0,
                          model(2'd0, b[6:0], len, dn[0], 3'd6, 1'b0));
                end
            end
        end

        // R6 illegal mode aborts on every page
        for (int p = 0; p < 8; p++) begin
            probe("R6 mode 2 abort", 2'd2, {p[2:0], 13'h0000}, 1'b0, 1'b0, 3'b110);
            probe("R6 mode 2 abort", 2'd2, {p[2:0], 13'h1FC7}, 1'b1, 1'b1, 3'b110);
        end

        // R11 data-space selection
        cfg_write(psel(1'b0, 2'd0, 1'b0, 3'd1), dword(7'd127, 1'b0, 3'd6));
        cfg_write(psel(1'b0, 2'd0, 1'b1, 3'd1), dword(7'd127, 1'b0, 3'd0));
        cfg_write(psel(1'b0, 2'd1, 1'b0, 3'd1), dword(7'd127, 1'b0, 3'd6));
        cfg_write(psel(1'b0, 2'd3, 1'b0, 3'd1), dword(7'd127, 1'b0, 3'd6));
        cfg_write(psel(1'b0, 2'd3, 1'b1, 3'd1), dword(7'd127, 1'b0, 3'd2));
        cfg_write(8'h82, 16'h0000);
        probe("R11 kernel data, D off", 2'd0, 16'h2040, 1'b0, 1'b0, 3'b000);
        cfg_write(8'h82, 16'h0004);
        probe("R11 kernel data, D on", 2'd0, 16'h2040, 1'b0, 1'b0, 3'b100);
        probe("R11 kernel fetch, D on", 2'd0, 16'h2040, 1'b0, 1'b1, 3'b000);
        cfg_write(8'h82, 16'h0002);
        probe("R11 super data, D on", 2'd1, 16'h2080, 1'b0, 1'b0, 3'b100);
        probe("R11 kernel data, only super D", 2'd0, 16'h2040, 1'b0, 1'b0, 3'b000);
        cfg_write(8'h82, 16'h0001);
        probe("R11 user data write, D on", 2'd3, 16'h20C0, 1'b1, 1'b0, 3'b001);
        probe("R11 user data read, D on", 2'd3, 16'h20C0, 1'b0, 1'b0, 3'b000);
        probe("R11 user fetch, D on", 2'd3, 16'h20C0, 1'b1, 1'b1, 3'b000);
        cfg_write(8'h82, 16'h0000);

        // R8 freeze: second abort does not overwrite
        access(2'd2, 16'h1234, 1'b0, 1'b0, ab);
        check("R8 first abort", {15'b0, ab}, 16'h0001);
        cfg_write(psel(1'b0, 2'd0, 1'b0, 3'd6), dword(7'd0, 1'b0, 3'd2));
        access(2'd0, {3'd6, 7'd10, 6'h00}, 1'b1, 1'b0, ab);
        check("R8 second abort still signalled", {15'b0, ab}, 16'h0001);
        cfg_read(8'h80, r); check("R8 reg0 frozen", r, 16'hC041);
        cfg_read(8'h81, r); check("R8 reg2 frozen", r, 16'h1234);
        cfg_write(8'h80, 16'h0001);
        cfg_read(8'h80, r); check("R8 reg0 after clear", r, 16'h0001);

        // R13 register-0 write and abort in the same cycle
        cfg_read(8'h81, saved);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 8'h80; cfg_wdata = 16'h0081;
        acc_valid = 1'b1; acc_mode = 2'd2; acc_vaddr = 16'h7ABC; acc_write = 1'b0; acc_ifetch = 1'b0;
        #1 ab = acc_abort;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check("R13 abort output in collision", {15'b0, ab}, 16'h0001);
        cfg_read(8'h80, r); check("R13 written value wins", r, 16'h0081);
        cfg_read(8'h81, r); check("R13 reg2 not updated", r, saved);

        // R1 / R10 reset clears registers 0, 2 and 3
        cfg_write(8'h82, 16'h0037);
        access(2'd2, 16'h5555, 1'b0, 1'b0, ab);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cfg_read(8'h80, r); check("R1 reg0 after reset", r, 16'h0000);
        cfg_read(8'h81, r); check("R1 reg2 after reset", r, 16'h0000);
        cfg_read(8'h82, r); check("R10 reg3 after reset", r, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule